// File: doc/BRIEF.md
# Burst Address Counter with Replay

This block produces the word address that one port of a synchronous banked memory presents inside the selected bank. A start address is captured from the external address bus when the strobe is asserted. From then on the counter can step through consecutive words, one per clock, to serve a burst without further address traffic.

Each capture is also copied into a shadow register. A replay request puts that saved start address back into the counter, so the same burst can run again without the external address being driven a second time. When the counter steps past the highest address it rolls over to zero and raises a one-cycle wrap indication. The bank select lines do not pass through this block.

All three controls are active low and are sampled on the rising clock edge. A new address appears on the output just after the edge that samples the command.

Top module: `burst_addr_gen`

## Requirements
- R1: While the active-low reset `rstN` is low, `curAddr` is 0 and `wrapPulse` is 0.
- R2: If `strobeN` is low and `replayN` is high at a rising edge, `curAddr` takes the value of `extAddr` after that edge, and the shadow start register takes the same value.
- R3: If `advanceN` is low and both `strobeN` and `replayN` are high at a rising edge, `curAddr` increases by one after that edge, modulo 2^ADDR_W.
- R4: If `strobeN`, `advanceN` and `replayN` are all high at a rising edge, `curAddr` keeps its value and `wrapPulse` is 0 after that edge.
- R5: If `replayN` is low at a rising edge, `curAddr` takes the shadow start value after that edge, whatever `strobeN`, `advanceN` and `extAddr` are. The shadow value is left unchanged, even when `strobeN` is also low.
- R6: If `strobeN` and `advanceN` are both low at a rising edge and `replayN` is high, the load wins and no increment takes place.
- R7: An increment from the all-ones address gives 0 and sets `wrapPulse` high for exactly the one cycle after that edge. In every other cycle `wrapPulse` is low, including after loads and replays.
- R8: The shadow start register resets to 0, so a replay before any load sets `curAddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all commands are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| extAddr | input | ADDR_W | External start address |
| strobeN | input | 1 | Active-low load strobe |
| advanceN | input | 1 | Active-low count enable |
| replayN | input | 1 | Active-low replay request |
| curAddr | output | ADDR_W | Current in-bank word address |
| wrapPulse | output | 1 | High for one cycle after a rollover from the top address to 0 |

## Verification
Every result is due one edge after its command: the command is sampled at a rising edge, and both `curAddr` and `wrapPulse` come straight from registers written on that edge. The bench drives each command at a falling edge and lets one rising edge pass. It compares both outputs at the next falling edge against an arithmetic model before it drives the next command. The checks sweep every start address of a 4-bit instance against all eight combinations of the three controls. They also include a run of increments that passes the top address twice.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // decoded command handed from control to datapath; at most one bit is set
  typedef struct packed {
    logic doReplay;
    logic doLoad;
    logic doStep;
  } cmdStrobes_t;

endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic        strobeN,
  input  logic        advanceN,
  input  logic        replayN,
  output cmdStrobes_t cmd
);

  logic wantReplay;
  logic wantLoad;
  logic wantStep;

  assign wantReplay = ~replayN;
  assign wantLoad   = ~strobeN;
  assign wantStep   = ~advanceN;

  // fixed priority: replay, then load, then step
  always_comb begin
    cmd = '0;
    if (wantReplay)
      cmd.doReplay = 1'b1;
    else if (wantLoad)
      cmd.doLoad = 1'b1;
    else if (wantStep)
      cmd.doStep = 1'b1;
  end

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       cmd,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wrapPulse
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] countQ;
  logic [ADDR_W-1:0] shadowQ;
  logic [ADDR_W-1:0] countD;
  logic              atTop;
  logic              wrapD;

  assign atTop = (countQ == TOP_ADDR);

  always_comb begin
    countD = countQ;
    wrapD  = 1'b0;
    if (cmd.doReplay)
      countD = shadowQ;
    else if (cmd.doLoad)
      countD = extAddr;
    else if (cmd.doStep) begin
      countD = countQ + 1'b1;
      wrapD  = atTop;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ    <= '0;
      shadowQ   <= '0;
      wrapPulse <= 1'b0;
    end else begin
      countQ    <= countD;
      wrapPulse <= wrapD;
      if (cmd.doLoad)
        shadowQ <= extAddr;
    end
  end

  assign curAddr = countQ;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              strobeN,
  input  logic              advanceN,
  input  logic              replayN,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wrapPulse
);

  cmdStrobes_t cmd;

  burst_ctl u_ctl (
    .strobeN (strobeN),
    .advanceN(advanceN),
    .replayN (replayN),
    .cmd     (cmd)
  );

  burst_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .extAddr  (extAddr),
    .curAddr  (curAddr),
    .wrapPulse(wrapPulse)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] extAddr,
  input logic              strobeN,
  input logic              advanceN,
  input logic              replayN,
  input logic [ADDR_W-1:0] curAddr,
  input logic              wrapPulse
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  // independent record of the last effective load
  logic [ADDR_W-1:0] lastLoad;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lastLoad <= '0;
    else if (replayN && !strobeN)
      lastLoad <= extAddr;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |-> (curAddr == '0 && !wrapPulse));

  // R2 and R6: the load wins over the count enable
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (replayN && !strobeN) |=> (curAddr == $past(extAddr)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (replayN && strobeN && !advanceN) |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (replayN && strobeN && advanceN) |=> ($stable(curAddr) && !wrapPulse));

  // R5 and R8: the checker's own record starts at zero
  assert_replay_R5: assert property (@(posedge clk) disable iff (!rstN)
    !replayN |=> (curAddr == $past(lastLoad) && !wrapPulse));

  assert_wrap_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (replayN && strobeN && !advanceN && curAddr == TOP_ADDR) |=> wrapPulse);

  assert_wrap_only_at_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (curAddr == '0));

  assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> !wrapPulse);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .extAddr  (extAddr),
  .strobeN  (strobeN),
  .advanceN (advanceN),
  .replayN  (replayN),
  .curAddr  (curAddr),
  .wrapPulse(wrapPulse)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int SPAN = 1 << AW;
  localparam int TOP = SPAN - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] extAddr;
  logic          strobeN, advanceN, replayN;
  logic [AW-1:0] curAddr;
  logic          wrapPulse;

  int total = 0;
  int bad = 0;
  int mCnt = 0;
  int mShadow = 0;
  int mWrap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .strobeN(strobeN),
    .advanceN(advanceN), .replayN(replayN), .curAddr(curAddr), .wrapPulse(wrapPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; drives, lets one rising edge pass, checks at next falling edge
  task automatic runCycle(input logic s, input logic a, input logic r, input int ext);
    string tag;
    strobeN  = s;
    advanceN = a;
    replayN  = r;
    extAddr  = ext[AW-1:0];
    @(posedge clk);
    mWrap = 0;
    if (!r) begin
      mCnt = mShadow;
      tag = "R5";
    end else if (!s) begin
      mCnt = ext % SPAN;
      mShadow = mCnt;
      tag = a ? "R2" : "R6";
    end else if (!a) begin
      mWrap = (mCnt == TOP) ? 1 : 0;
      mCnt = (mCnt + 1) % SPAN;
      tag = "R3";
    end else begin
      tag = "R4";
    end
    @(negedge clk);
    check(tag, int'(curAddr), mCnt);
    check("R7 wrapPulse", int'(wrapPulse), mWrap);
  endtask

  initial begin
    rstN = 1'b0;
    strobeN = 1'b0;
    advanceN = 1'b0;
    replayN = 1'b1;
    extAddr = '1;
    repeat (3) @(negedge clk);
    check("R1 curAddr", int'(curAddr), 0);
    check("R1 wrapPulse", int'(wrapPulse), 0);
    rstN = 1'b1;

    // replay before any load: steps first, then back to zero (R8)
    runCycle(1, 0, 1, 0);
    runCycle(1, 0, 1, 0);
    runCycle(1, 0, 1, 9);
    runCycle(1, 1, 0, 7);
    check("R8 replay before load", int'(curAddr), 0);

    // sweep every start address against every control combination
    for (int a = 0; a < SPAN; a++) begin
      for (int c = 0; c < 8; c++) begin
        runCycle(0, 1, 1, a);
        runCycle(c[2], c[1], c[0], a ^ 5);
        runCycle(1, 0, 1, 0);
        runCycle(1, 1, 0, a ^ 10);
      end
    end

    // rollover at the top address (R7)
    runCycle(0, 1, 1, TOP);
    runCycle(1, 0, 1, 0);
    check("R7 rollover to zero", int'(curAddr), 0);
    runCycle(1, 0, 1, 0);
    runCycle(1, 1, 1, 0);

    // long run that passes the top twice, then replay (R3, R7, R5)
    runCycle(0, 1, 1, 3);
    for (int k = 0; k < 2 * SPAN + 3; k++) runCycle(1, 0, 1, k);
    runCycle(1, 0, 0, 12);
    check("R5 replay after run", int'(curAddr), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule